// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from two classes of source and tells the CPU which handler to run. The first class holds critical error sources. Their vectors start at 0 and must stay below 32. The global mask never blocks them. The second class holds ordinary device sources. Their vectors start at 32, and the CPU can hold them off as a group by raising `mask_en`.

The CPU sees a single `irq` line. When `irq` is high, the CPU pulses `ack`. One cycle later the controller presents the vector number of the winning request. The CPU uses that number as an index into its handler table.

The controller keeps a small stack of in-service priority levels. A lower vector number means a higher priority. While a level is in service, only requests with a strictly lower vector can raise `irq`. Such a request preempts the running handler, and its level is pushed on top of the stack. An end-of-interrupt pulse pops the top level, which restores the threshold of the interrupted handler.

The vector return has no back-pressure. `ack` acts as the ready side, and the vector is valid for exactly one cycle, so the CPU must take it in that cycle.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: After reset, `irq` and `vec_valid` are low and no level is in service.
- R2: Critical source i returns vector i. Device source j returns vector 32+j.
- R3: Among requests that can be served together, the lowest vector wins, so any critical source beats every device source.
- R4: While `mask_en` is high, device requests neither raise `irq` nor win at `ack`. Critical requests are unaffected.
- R5: `vec_valid` is high exactly in the cycle after an `ack` cycle, and `vec` then carries the result chosen from the request lines in the `ack` cycle.
- R6: When nothing is eligible at `ack`, `vec` is 255 and no level is pushed.
- R7: A non-spurious `ack` pushes the granted vector as the new level. Requests with a vector equal to or above that level then neither raise `irq` nor win.
- R8: A request with a vector below the current level raises `irq`, and its `ack` nests above the current level.
- R9: `eoi` pops the top level, which restores the previous threshold. `eoi` with no level in service changes nothing.
- R10: With the level stack full, `irq` stays low and `ack` returns 255.
- R11: Requests are level-sensitive. A line dropped before `ack` yields no vector, and with no request `irq` is low.
- R12: An `eoi` in the same cycle as `ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | NMI_N | Critical request lines, bit i maps to vector i |
| dev_req | input | DEV_N | Device request lines, bit j maps to vector 32+j |
| mask_en | input | 1 | High blocks all device requests |
| irq | output | 1 | Interrupt request to the CPU |
| ack | input | 1 | One-cycle CPU acknowledge |
| eoi | input | 1 | One-cycle end-of-interrupt, pops one level |
| vec_valid | output | 1 | High for one cycle after `ack` |
| vec | output | 8 | Granted vector, or 255 when spurious |

## Verification
The hardest states to reach from the ports are nested service and a full level stack. In both, only the ordering of earlier grants decides whether a new request may raise `irq`. The bench builds these states one grant at a time. It raises a single source, acknowledges it, and drops the line. Then, for every pair of sources, it offers a second request on top of the first. To fill the stack it grants device vectors in falling order until all levels are used, then offers a critical request that must be refused. Separately, every request pattern is swept under both mask settings against a small arithmetic model of the level stack.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VEC_W    = 8;
  localparam int LVL_W    = 9;
  localparam int DEV_BASE = 32;
  localparam logic [VEC_W-1:0] SPURIOUS = 8'hFF;
  localparam logic [LVL_W-1:0] LVL_NONE = 9'd256;
endpackage

// File: rtl/vic_first_set.sv
module vic_first_set #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // Lowest set index wins: the downward scan keeps overwriting, so the last write is the lowest index.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_lvl,
  input  logic         pop,
  output logic [W-1:0] top_lvl,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign wr_ptr = AW'(cnt);
  assign rd_ptr = AW'(cnt - CW'(1));
  assign top_lvl = empty ? '0 : slots[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (push && !full) begin
      slots[wr_ptr] <= push_lvl;
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl #(
  parameter int NMI_N = 4,
  parameter int DEV_N = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NMI_N-1:0] nmi_req,
  input  logic [DEV_N-1:0] dev_req,
  input  logic             mask_en,
  output logic             irq,
  input  logic             ack,
  input  logic             eoi,
  output logic             vec_valid,
  output logic [7:0]       vec
);
  import vic_pkg::*;

  localparam int NIW = (NMI_N > 1) ? $clog2(NMI_N) : 1;
  localparam int DIW = (DEV_N > 1) ? $clog2(DEV_N) : 1;

  logic [VEC_W-1:0] top_lvl, win_vec;
  logic             stk_empty, stk_full;
  logic [LVL_W-1:0] thr;
  logic [NMI_N-1:0] nmi_elig;
  logic [DEV_N-1:0] dev_elig;
  logic             nmi_hit, dev_hit, have_win;
  logic [NIW-1:0]   nmi_idx;
  logic [DIW-1:0]   dev_idx;
  logic             do_push, do_pop;

  // Threshold: only vectors strictly below it may be served
  assign thr = stk_empty ? LVL_NONE : {1'b0, top_lvl};

  for (genvar i = 0; i < NMI_N; i++) begin : g_nmi
    assign nmi_elig[i] = nmi_req[i] && !stk_full && (LVL_W'(i) < thr);
  end

  for (genvar j = 0; j < DEV_N; j++) begin : g_dev
    assign dev_elig[j] = dev_req[j] && !stk_full && !mask_en &&
                         (LVL_W'(DEV_BASE + j) < thr);
  end

  vic_first_set #(.W(NMI_N), .IW(NIW)) u_nmi_pick (
    .bits(nmi_elig), .hit(nmi_hit), .idx(nmi_idx)
  );

  vic_first_set #(.W(DEV_N), .IW(DIW)) u_dev_pick (
    .bits(dev_elig), .hit(dev_hit), .idx(dev_idx)
  );

  assign have_win = nmi_hit || dev_hit;
  assign win_vec  = nmi_hit ? VEC_W'(nmi_idx)
                            : VEC_W'(DEV_BASE) + VEC_W'(dev_idx);
  assign irq      = have_win;
  assign do_push  = ack && have_win;
  assign do_pop   = eoi && !ack;

  vic_level_stack #(.DEPTH(DEPTH), .W(VEC_W)) u_levels (
    .clk(clk), .rst_n(rst_n),
    .push(do_push), .push_lvl(win_vec), .pop(do_pop),
    .top_lvl(top_lvl), .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec       <= SPURIOUS;
    end else begin
      vec_valid <= ack;
      if (ack) vec <= have_win ? win_vec : SPURIOUS;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NMI_N = 4,
  parameter int DEV_N = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NMI_N-1:0] nmi_req,
  input logic [DEV_N-1:0] dev_req,
  input logic             mask_en,
  input logic             irq,
  input logic             ack,
  input logic             vec_valid,
  input logic [7:0]       vec
);
  localparam logic [7:0] NMI_END = 8'(NMI_N);
  localparam logic [7:0] DEV_LO  = 8'd32;
  localparam logic [7:0] DEV_END = 8'(32 + DEV_N);

  p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  p_no_vec_without_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  p_mask_blocks_dev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_en && nmi_req == '0) |-> !irq);

  p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req == '0 && dev_req == '0) |-> !irq);

  p_vec_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec != 8'hFF) |->
      (vec < NMI_END || (vec >= DEV_LO && vec < DEV_END)));

  p_irq_gives_real_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (vec != 8'hFF));
endmodule

bind vectored_irq_ctrl vic_checker #(.NMI_N(NMI_N), .DEV_N(DEV_N)) u_vic_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .dev_req(dev_req),
  .mask_en(mask_en), .irq(irq), .ack(ack), .vec_valid(vec_valid), .vec(vec)
);

// File: tb/test_vectored_irq_ctrl.sv
module test_vectored_irq_ctrl;
  localparam int NMI_N = 4;
  localparam int DEV_N = 8;
  localparam int DEPTH = 4;
  localparam int SRC_N = NMI_N + DEV_N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NMI_N-1:0] nmi_req = '0;
  logic [DEV_N-1:0] dev_req = '0;
  logic mask_en = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic irq, vec_valid;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  int mstk [DEPTH];
  int mcnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vectored_irq_ctrl #(.NMI_N(NMI_N), .DEV_N(DEV_N), .DEPTH(DEPTH)) i_vectored_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .dev_req(dev_req),
    .mask_en(mask_en), .irq(irq), .ack(ack), .eoi(eoi),
    .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int src_vec(input int s);
    return (s < NMI_N) ? s : 32 + s - NMI_N;
  endfunction

  function automatic int exp_vec(input logic [NMI_N-1:0] n, input logic [DEV_N-1:0] d,
                                 input logic m);
    int thr;
    thr = (mcnt == 0) ? 256 : mstk[mcnt-1];
    if (mcnt == DEPTH) return 255;
    for (int i = 0; i < NMI_N; i++) if (n[i] && i < thr) return i;
    if (!m) for (int j = 0; j < DEV_N; j++) if (d[j] && 32 + j < thr) return 32 + j;
    return 255;
  endfunction

  task automatic set_src(input int s);
    nmi_req = '0; dev_req = '0;
    if (s < NMI_N) nmi_req[s] = 1'b1; else dev_req[s-NMI_N] = 1'b1;
  endtask

  // Pulse ack for one cycle; check the vector presented at the next negedge
  task automatic do_ack(input string tag, input int exp);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({tag, " vec_valid"}, int'(vec_valid), 1);
    chk({tag, " vec"}, int'(vec), exp);
    if (exp != 255 && mcnt < DEPTH) begin mstk[mcnt] = exp; mcnt++; end
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    if (mcnt > 0) mcnt--;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 vec_valid in reset", int'(vec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 vec_valid after reset", int'(vec_valid), 0);

    // R2 R3 R4 R6: every request pattern under both mask settings
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < (1 << SRC_N); p++) begin
        mask_en = m[0];
        nmi_req = p[NMI_N-1:0];
        dev_req = p[SRC_N-1:NMI_N];
        e = exp_vec(nmi_req, dev_req, mask_en);
        #1;
        chk("R3 R4 irq on pattern", int'(irq), (e != 255) ? 1 : 0);
        do_ack("R2 R3 R6 sweep", e);
        nmi_req = '0; dev_req = '0;
        if (mcnt > 0) do_eoi();
      end
    end
    mask_en = 1'b0;

    // R5: vec_valid is a single-cycle pulse
    @(negedge clk);
    chk("R5 vec_valid drops", int'(vec_valid), 0);

    // R7 R8: every pair, one in service and a second offered
    for (int a = 0; a < SRC_N; a++) begin
      for (int b = 0; b < SRC_N; b++) begin
        set_src(a);
        #1;
        do_ack("R7 first grant", src_vec(a));
        nmi_req = '0; dev_req = '0;
        set_src(b);
        e = exp_vec(nmi_req, dev_req, 1'b0);
        #1;
        if (src_vec(b) < src_vec(a)) begin
          chk("R8 preempt irq", int'(irq), 1);
          do_ack("R8 nested grant", e);
        end else begin
          chk("R7 held off irq", int'(irq), 0);
          do_ack("R7 held off ack", e);
        end
        nmi_req = '0; dev_req = '0;
        while (mcnt > 0) do_eoi();
      end
    end

    // R9: eoi with nothing in service changes nothing
    do_eoi();
    do_eoi();

    // R10: fill the stack with falling device vectors
    for (int j = DEPTH - 1; j >= 0; j--) begin
      dev_req = '0; dev_req[j] = 1'b1;
      #1;
      do_ack("R10 fill", 32 + j);
    end
    dev_req = '0;
    nmi_req = 4'b0001;
    #1;
    chk("R10 full irq", int'(irq), 0);
    do_ack("R10 full ack", 255);
    do_eoi();
    #1;
    chk("R9 restored irq", int'(irq), 1);
    do_ack("R9 restored grant", 0);
    nmi_req = '0;
    while (mcnt > 0) do_eoi();
    dev_req = '0; dev_req[DEV_N-1] = 1'b1;
    #1;
    chk("R9 empty after pops irq", int'(irq), 1);
    do_ack("R9 empty after pops", 32 + DEV_N - 1);
    dev_req = '0;
    do_eoi();

    // R9: pop restores a lower threshold
    dev_req = 8'b0000_1000;
    #1; do_ack("R9 outer", 35);
    dev_req = 8'b0000_0010;
    #1; do_ack("R9 inner", 33);
    dev_req = 8'b0000_0100;
    #1;
    chk("R9 34 blocked by 33", int'(irq), 0);
    do_eoi();
    #1;
    chk("R9 34 allowed after pop", int'(irq), 1);
    dev_req = '0;
    while (mcnt > 0) do_eoi();

    // R11: line dropped before ack
    dev_req = 8'b0001_0000;
    #1;
    chk("R11 irq raised", int'(irq), 1);
    dev_req = '0;
    #1;
    chk("R11 irq dropped", int'(irq), 0);
    do_ack("R11 dropped ack", 255);

    // R12: eoi together with ack is ignored
    dev_req = 8'b0000_0100;
    #1; do_ack("R12 grant", 34);
    dev_req = '0;
    eoi = 1'b1;
    do_ack("R12 ack with eoi", 255);
    eoi = 1'b0;
    dev_req = 8'b0000_1000;
    #1;
    chk("R12 level kept", int'(irq), 0);
    do_eoi();
    #1;
    chk("R12 level popped later", int'(irq), 1);
    dev_req = '0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule